// File: doc/BRIEF.md
# LCD Interrupt Status and Enable Unit

This unit gathers single-cycle event pulses from a display controller's raster engine and its frame-fetch DMA and turns them into sticky status bits. Software sees the pending events twice: once unfiltered and once filtered by an enable mask. Software clears a pending event by writing a one to its bit in the filtered status register.

The enable mask has no plain write path. One register address sets mask bits and another clears them, so a handler can change one source without reading the mask first. A single level interrupt line is high while any enabled event is pending. A write to the end-of-interrupt address pulls the line low for one cycle. If work is still pending after that cycle, the line rises again, so an edge-sensitive interrupt controller sees a new edge.

Access uses a simple single-cycle register port. A write takes effect at the clock edge where it is sampled. Read data is registered and appears one cycle after the read strobe.

Top module: `lcd_irq_ctrl`

## Requirements
- R1: After synchronous reset, the raw status, the enable mask, the interrupt line and the read data are all zero.
- R2: The event input bits map to status bits at the same positions: frame done 0, raster done 1, sync lost 2, AC-bias count 3, FIFO underflow 5, palette loaded 6, end of frame buffer 0 at 8, end of frame buffer 1 at 9. An event pulse sets its bit, and the bit stays set until software clears it. Bits 4, 7 and 10 and above always read zero and cannot be set.
- R3: Writing to the filtered status address 0x5C clears every status bit that is one in the write data and leaves the others unchanged. Writes to the raw status address 0x58 have no effect.
- R4: An event that arrives in the same cycle as a clear of its bit leaves the bit set.
- R5: Writing to enable-set at 0x60 sets each mask bit that is one in the data. Zero bits are unchanged, and unimplemented bits stay zero.
- R6: Writing to enable-clear at 0x64 clears each mask bit that is one in the data. Zero bits are unchanged. Reading either 0x60 or 0x64 returns the current mask.
- R7: Reading 0x5C returns the raw status ANDed with the mask. Reading 0x58 returns the raw status whatever the mask.
- R8: The interrupt line is registered. It is high in the cycle after a cycle in which any filtered status bit is set, and low otherwise. An event sampled at edge E raises the line at edge E+1. A clear sampled at edge W lowers it at edge W+1.
- R9: A write to 0x68 drives the line low in the following cycle, whatever the data. One cycle later the line rises again if a filtered bit is still pending. Reading 0x68 returns zero.
- R10: Read data updates at the edge that samples the read strobe. Addresses with no register return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | N_EVT (10) | Single-cycle event pulses, one per status bit |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W (8) | Byte address of the accessed register |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Registered read data |
| irq_o | output | 1 | Level interrupt line |

## Verification
Two pairs of functions can meet in one clock cycle. The first is a hardware event setting a status bit while software write-one-clears that same bit. The bench drives the event pulse and the clear write in the same cycle. It then reads the raw register and expects the colliding bit to remain set, while the other bit cleared by the same write goes to zero. The second pair is the end-of-interrupt write and a pending enabled event. The bench checks that the line is low in exactly the cycle after that write and high again in the next cycle.

// File: rtl/lcd_irq_pkg.sv
package lcd_irq_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RAW,
    SEL_FILT,
    SEL_ENSET,
    SEL_ENCLR,
    SEL_EOI
  } reg_sel_e;

  localparam int unsigned EVT_FRAME_DONE  = 0;
  localparam int unsigned EVT_RASTER_DONE = 1;
  localparam int unsigned EVT_SYNC_LOST   = 2;
  localparam int unsigned EVT_ACB_COUNT   = 3;
  localparam int unsigned EVT_FIFO_UNDER  = 5;
  localparam int unsigned EVT_PAL_LOADED  = 6;
  localparam int unsigned EVT_FB0_END     = 8;
  localparam int unsigned EVT_FB1_END     = 9;

  localparam logic [9:0] EVT_IMPL_DEFAULT =
      (10'd1 << EVT_FRAME_DONE) | (10'd1 << EVT_RASTER_DONE) |
      (10'd1 << EVT_SYNC_LOST)  | (10'd1 << EVT_ACB_COUNT)   |
      (10'd1 << EVT_FIFO_UNDER) | (10'd1 << EVT_PAL_LOADED)  |
      (10'd1 << EVT_FB0_END)    | (10'd1 << EVT_FB1_END);

endpackage

// File: rtl/lcd_irq_decode.sv
module lcd_irq_decode
  import lcd_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFS_RAW   = 'h58,
  parameter logic [ADDR_W-1:0] OFS_FILT  = 'h5C,
  parameter logic [ADDR_W-1:0] OFS_ENSET = 'h60,
  parameter logic [ADDR_W-1:0] OFS_ENCLR = 'h64,
  parameter logic [ADDR_W-1:0] OFS_EOI   = 'h68
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);

  always_comb begin
    if (addr_i == OFS_RAW)        sel_o = SEL_RAW;
    else if (addr_i == OFS_FILT)  sel_o = SEL_FILT;
    else if (addr_i == OFS_ENSET) sel_o = SEL_ENSET;
    else if (addr_i == OFS_ENCLR) sel_o = SEL_ENCLR;
    else if (addr_i == OFS_EOI)   sel_o = SEL_EOI;
    else                          sel_o = SEL_NONE;
  end

endmodule

// File: rtl/lcd_irq_status.sv
module lcd_irq_status #(
  parameter int unsigned      N_EVT    = 10,
  parameter logic [N_EVT-1:0] EVT_IMPL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EVT-1:0] evt_i,
  input  logic             clr_en_i,
  input  logic [N_EVT-1:0] clr_bits_i,
  output logic [N_EVT-1:0] raw_o
);

  logic unused_evt;
  assign unused_evt = ^(evt_i & ~EVT_IMPL) ^ ^(clr_bits_i & ~EVT_IMPL);

  for (genvar i = 0; i < N_EVT; i++) begin : g_bit
    if (EVT_IMPL[i]) begin : g_impl
      logic sticky_q;
      always_ff @(posedge clk) begin
        if (rst)                               sticky_q <= 1'b0;
        else if (evt_i[i])                     sticky_q <= 1'b1;
        else if (clr_en_i && clr_bits_i[i])    sticky_q <= 1'b0;
      end
      assign raw_o[i] = sticky_q;
    end else begin : g_tie
      assign raw_o[i] = 1'b0;
    end
  end

endmodule

// File: rtl/lcd_irq_enable.sv
module lcd_irq_enable #(
  parameter int unsigned      N_EVT    = 10,
  parameter logic [N_EVT-1:0] EVT_IMPL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en_i,
  input  logic             clr_en_i,
  input  logic [N_EVT-1:0] bits_i,
  output logic [N_EVT-1:0] mask_o
);

  logic unused_bits;
  assign unused_bits = ^(bits_i & ~EVT_IMPL);

  for (genvar i = 0; i < N_EVT; i++) begin : g_bit
    if (EVT_IMPL[i]) begin : g_impl
      logic en_q;
      always_ff @(posedge clk) begin
        if (rst)                        en_q <= 1'b0;
        else if (set_en_i && bits_i[i]) en_q <= 1'b1;
        else if (clr_en_i && bits_i[i]) en_q <= 1'b0;
      end
      assign mask_o[i] = en_q;
    end else begin : g_tie
      assign mask_o[i] = 1'b0;
    end
  end

endmodule

// File: rtl/lcd_irq_line.sv
module lcd_irq_line (
  input  logic clk,
  input  logic rst,
  input  logic pending_i,
  input  logic eoi_i,
  output logic irq_o
);

  always_ff @(posedge clk) begin
    if (rst)        irq_o <= 1'b0;
    else if (eoi_i) irq_o <= 1'b0;
    else            irq_o <= pending_i;
  end

endmodule

// File: rtl/lcd_irq_ctrl.sv
module lcd_irq_ctrl
  import lcd_irq_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 8,
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       N_EVT     = 10,
  parameter logic [N_EVT-1:0]  EVT_IMPL  = N_EVT'(EVT_IMPL_DEFAULT),
  parameter logic [ADDR_W-1:0] OFS_RAW   = 'h58,
  parameter logic [ADDR_W-1:0] OFS_FILT  = 'h5C,
  parameter logic [ADDR_W-1:0] OFS_ENSET = 'h60,
  parameter logic [ADDR_W-1:0] OFS_ENCLR = 'h64,
  parameter logic [ADDR_W-1:0] OFS_EOI   = 'h68
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);

  localparam int unsigned PAD_W = DATA_W - N_EVT;

  reg_sel_e         sel;
  logic [N_EVT-1:0] wbits;
  logic [N_EVT-1:0] raw_q;
  logic [N_EVT-1:0] en_q;
  logic [N_EVT-1:0] filt;
  logic             unused_wide;

  assign wbits       = wdata_i[N_EVT-1:0];
  assign unused_wide = ^wdata_i[DATA_W-1:N_EVT];
  assign filt        = raw_q & en_q;

  lcd_irq_decode #(
    .ADDR_W(ADDR_W), .OFS_RAW(OFS_RAW), .OFS_FILT(OFS_FILT),
    .OFS_ENSET(OFS_ENSET), .OFS_ENCLR(OFS_ENCLR), .OFS_EOI(OFS_EOI)
  ) u_decode (
    .addr_i(addr_i),
    .sel_o (sel)
  );

  lcd_irq_status #(.N_EVT(N_EVT), .EVT_IMPL(EVT_IMPL)) u_status (
    .clk       (clk),
    .rst       (rst),
    .evt_i     (evt_i),
    .clr_en_i  (wr_en_i && sel == SEL_FILT),
    .clr_bits_i(wbits),
    .raw_o     (raw_q)
  );

  lcd_irq_enable #(.N_EVT(N_EVT), .EVT_IMPL(EVT_IMPL)) u_enable (
    .clk     (clk),
    .rst     (rst),
    .set_en_i(wr_en_i && sel == SEL_ENSET),
    .clr_en_i(wr_en_i && sel == SEL_ENCLR),
    .bits_i  (wbits),
    .mask_o  (en_q)
  );

  lcd_irq_line u_line (
    .clk      (clk),
    .rst      (rst),
    .pending_i(|filt),
    .eoi_i    (wr_en_i && sel == SEL_EOI),
    .irq_o    (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (rd_en_i) begin
      case (sel)
        SEL_RAW:             rdata_o <= {{PAD_W{1'b0}}, raw_q};
        SEL_FILT:            rdata_o <= {{PAD_W{1'b0}}, filt};
        SEL_ENSET, SEL_ENCLR: rdata_o <= {{PAD_W{1'b0}}, en_q};
        default:             rdata_o <= '0;
      endcase
    end
  end

endmodule

// File: rtl/lcd_irq_ctrl_chk.sv
module lcd_irq_ctrl_chk #(
  parameter int unsigned       ADDR_W    = 8,
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       N_EVT     = 10,
  parameter logic [N_EVT-1:0]  EVT_IMPL  = '1,
  parameter logic [ADDR_W-1:0] OFS_FILT  = 'h5C,
  parameter logic [ADDR_W-1:0] OFS_ENSET = 'h60,
  parameter logic [ADDR_W-1:0] OFS_ENCLR = 'h64,
  parameter logic [ADDR_W-1:0] OFS_EOI   = 'h68
) (
  input logic              clk,
  input logic              rst,
  input logic [N_EVT-1:0]  evt_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [N_EVT-1:0]  raw_q,
  input logic [N_EVT-1:0]  en_q,
  input logic              irq_o
);

  // R2: an event pulse on an implemented bit is recorded
  p_evt_sets_r2: assert property (@(posedge clk) disable iff (rst)
    (|(evt_i & EVT_IMPL)) |=>
      ((raw_q & $past(evt_i & EVT_IMPL)) == $past(evt_i & EVT_IMPL)));

  // R2: unimplemented positions never hold a one
  p_no_ghost_r2: assert property (@(posedge clk) disable iff (rst)
    ((raw_q & ~EVT_IMPL) == '0) && ((en_q & ~EVT_IMPL) == '0));

  // R3 and R4: write-one-clear removes a bit unless its event coincides
  p_w1c_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == OFS_FILT) |=>
      ((raw_q & $past(wdata_i[N_EVT-1:0]) & ~$past(evt_i)) == '0));

  // R5
  p_en_set_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == OFS_ENSET) |=>
      ((en_q & $past(wdata_i[N_EVT-1:0] & EVT_IMPL)) ==
       $past(wdata_i[N_EVT-1:0] & EVT_IMPL)));

  // R6
  p_en_clr_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == OFS_ENCLR) |=>
      ((en_q & $past(wdata_i[N_EVT-1:0])) == '0));

  // R8: line tracks pending enabled status with one cycle of latency
  p_line_follow_r8: assert property (@(posedge clk) disable iff (rst)
    !(wr_en_i && addr_i == OFS_EOI) |=> (irq_o == $past(|(raw_q & en_q))));

  // R9: end-of-interrupt forces one low cycle
  p_eoi_low_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == OFS_EOI) |=> !irq_o);

endmodule

bind lcd_irq_ctrl lcd_irq_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_EVT(N_EVT), .EVT_IMPL(EVT_IMPL),
  .OFS_FILT(OFS_FILT), .OFS_ENSET(OFS_ENSET), .OFS_ENCLR(OFS_ENCLR),
  .OFS_EOI(OFS_EOI)
) u_chk (
  .clk(clk), .rst(rst), .evt_i(evt_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .raw_q(raw_q), .en_q(en_q), .irq_o(irq_o)
);

// File: tb/test_lcd_irq_ctrl.sv
`timescale 1ns/1ps
module test_lcd_irq_ctrl;

  localparam logic [7:0] A_RAW = 8'h58, A_FILT = 8'h5C, A_ENS = 8'h60,
                         A_ENC = 8'h64, A_EOI = 8'h68;
  localparam logic [31:0] IMPL = 32'h36F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  evt = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  lcd_irq_ctrl i_lcd_irq_ctrl (
    .clk(clk), .rst(rst), .evt_i(evt), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(input logic [9:0] e);
    evt = e;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 rdata", rdata, 0);
    check("R1 irq", {31'd0, irq}, 0);
    rd(A_RAW, d); check("R1 raw", d, 0);
    rd(A_ENS, d); check("R1 mask", d, 0);
  endtask

  task automatic t_bitmap();
    logic [31:0] d;
    wr(A_ENS, 32'hFFFF_FFFF);
    rd(A_ENS, d); check("R5 set all", d, IMPL);
    pulse(10'h3FF);
    rd(A_RAW, d); check("R2 map", d, IMPL);
    @(negedge clk);
    rd(A_RAW, d); check("R2 sticky", d, IMPL);
    wr(A_FILT, 32'hFFFF_FFFF);
    rd(A_RAW, d); check("R3 clear all", d, 0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    pulse(10'h301);
    wr(A_RAW, 32'h3FF);
    rd(A_RAW, d); check("R3 raw write ignored", d, 32'h301);
    wr(A_FILT, 32'h100);
    rd(A_RAW, d); check("R3 partial clear", d, 32'h201);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    evt = 10'h001; wr_en = 1'b1; addr = A_FILT; wdata = 32'h201;
    @(negedge clk);
    evt = '0; wr_en = 1'b0; wdata = '0;
    rd(A_RAW, d); check("R4 event beats clear", d, 32'h001);
    wr(A_FILT, 32'h3FF);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(A_ENC, 32'hFFFF_FFFF);
    rd(A_ENC, d); check("R6 clear all", d, 0);
    wr(A_ENS, 32'h003);
    wr(A_ENC, 32'h002);
    rd(A_ENS, d); check("R6 partial clear", d, 32'h001);
    rd(A_ENC, d); check("R6 read via clr addr", d, 32'h001);
    wr(A_ENS, 32'h000);
    rd(A_ENS, d); check("R5 zeros keep", d, 32'h001);
    pulse(10'h005);
    rd(A_FILT, d); check("R7 filtered", d, 32'h001);
    rd(A_RAW, d); check("R7 raw unfiltered", d, 32'h005);
    wr(A_FILT, 32'h3FF);
    wr(A_ENC, 32'h3FF);
  endtask

  task automatic t_irq();
    wr(A_ENS, 32'h020);
    pulse(10'h004);
    @(negedge clk);
    check("R8 masked event quiet", {31'd0, irq}, 0);
    pulse(10'h020);
    check("R8 latency low", {31'd0, irq}, 0);
    @(negedge clk);
    check("R8 asserted", {31'd0, irq}, 1);
    wr(A_FILT, 32'h020);
    check("R8 still high", {31'd0, irq}, 1);
    @(negedge clk);
    check("R8 dropped", {31'd0, irq}, 0);
  endtask

  task automatic t_eoi();
    logic [31:0] d;
    pulse(10'h020);
    @(negedge clk);
    check("R9 pre high", {31'd0, irq}, 1);
    wr(A_EOI, 32'h0);
    check("R9 low after eoi", {31'd0, irq}, 0);
    @(negedge clk);
    check("R9 reasserted", {31'd0, irq}, 1);
    rd(A_EOI, d); check("R9 eoi reads zero", d, 0);
    wr(A_FILT, 32'h3FF);
    @(negedge clk);
    wr(A_EOI, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R9 idle stays low", {31'd0, irq}, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    pulse(10'h001);
    rd(8'h00, d); check("R10 unmapped 00", d, 0);
    rd(8'h6C, d); check("R10 unmapped 6C", d, 0);
    rd(A_RAW, d); check("R10 read after strobe", d, 32'h001);
  endtask

  initial begin
    #20000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_bitmap();
    t_w1c();
    t_collide();
    t_enable();
    t_irq();
    t_eoi();
    t_unmapped();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule